// File: doc/BRIEF.md
# Per-Output Cell Queue Buffer

This block sits at the input side of a cell switch. Each arriving fixed-size cell carries the index of the output port it is bound for, and the block files it into a FIFO that is dedicated to that output. With one FIFO per output, a cell waiting for a congested output cannot hold back cells that are bound for idle outputs. This removes the head-of-line blocking that a single shared input FIFO would suffer from.

Every cycle the block reports which output queues hold at least one cell and which are full. The fabric scheduler answers with a grant vector. A grant for output k removes the oldest cell of queue k in that same cycle and places it on the read bus. All queues share one storage array that is split into fixed, equal partitions. That array takes at most one write and one read per cycle, so it needs to run only at the rate of a single port.

Top module: `voq_buffer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `q_nonempty` and `q_full` are all zero and no cell can be read.
- R2: A cell written with `wr_valid` high and destination `wr_port` = k, while `q_full[k]` is low, is appended to queue k, and `q_nonempty[k]` is high from the next cycle.
- R3: While `rd_grant` selects queue k and queue k is not empty, `rd_valid` is high in that same cycle and `rd_cell` carries the oldest cell of queue k. That cell is removed at the clock edge, so cells leave each queue in the order they were written. When `rd_valid` is low, `rd_cell` is zero.
- R4: A queue that is never granted does not delay cells in any other queue. Those cells are delivered as soon as their own queues are granted.
- R5: With the default depth, each queue holds 8 cells. `q_full[k]` is high exactly when queue k holds 8 cells. A write aimed at a queue whose `q_full` bit is high in that cycle is dropped, leaves the queue's contents unchanged, and does not affect other queues.
- R6: A grant that selects an empty queue produces no read: `rd_valid` stays low and `rd_err` is high for that cycle only. Queue state is unchanged apart from any write in the same cycle. `rd_err` is low in every other cycle.
- R7: When a write and a read hit the same non-full queue in the same cycle, that queue's occupancy is unchanged. The read returns the old head, and the new cell joins the tail.
- R8: At most one cell is read per cycle. If `rd_grant` has more than one bit set, only the lowest-indexed set bit is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | A cell is offered on `wr_cell` this cycle |
| wr_port | input | 2 | Destination output index of the offered cell |
| wr_cell | input | 32 | Cell payload to store |
| q_full | output | 4 | Per-queue full flag; a write to a full queue is dropped |
| rd_grant | input | 4 | Per-output grant from the fabric scheduler |
| rd_valid | output | 1 | `rd_cell` holds a cell removed this cycle |
| rd_cell | output | 32 | Head cell of the granted queue, zero when `rd_valid` is low |
| rd_err | output | 1 | Pulse: the selected grant targeted an empty queue |
| q_nonempty | output | 4 | Per-queue flag, high when the queue holds a cell |

## Verification
The write path and the read path can act in the same cycle, either on the same queue or on two different queues. This matters most when the targeted queue is full or empty at that edge. The bench provokes these cases directly: a write and a grant to a queue holding one cell, a write to a full queue while other queues are drained, and a grant to an empty queue together with a write. It then runs long random mixes of writes and grants. A behavioural model built from per-queue lists predicts, every cycle, the flags, the read cell and the error pulse. Occupancy over time shows whether each collision was resolved correctly.

// File: rtl/voq_pkg.sv
package voq_pkg;
   // Index of the lowest set bit of a request vector; width-generic via 32-bit carrier
   function automatic int unsigned lowest_set(input logic [31:0] vec, input int unsigned n);
      int unsigned idx;
      idx = 0;
      for (int i = 31; i >= 0; i--) begin
         if (i < n && vec[i]) idx = i;
      end
      return idx;
   endfunction
endpackage

// File: rtl/voq_queue_ctrl.sv
module voq_queue_ctrl #(
   parameter int DEPTH = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [CNT_W-1:0] occ,
   output logic             empty,
   output logic             full
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   occ <= occ + 1'b1;
            2'b01:   occ <= occ - 1'b1;
            default: occ <= occ;
         endcase
      end
   end

   assign empty = (occ == '0);
   assign full  = (occ == CNT_W'(DEPTH));
endmodule

// File: rtl/voq_cell_ram.sv
module voq_cell_ram #(
   parameter int WIDTH = 32,
   parameter int WORDS = 32,
   localparam int AW = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] store [WORDS];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/voq_buffer.sv
module voq_buffer #(
   parameter int NUM_OUT = 4,
   parameter int DEPTH   = 8,
   parameter int CELL_W  = 32,
   localparam int PORT_W = $clog2(NUM_OUT),
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int WORDS  = NUM_OUT * DEPTH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [PORT_W-1:0] wr_port,
   input  logic [CELL_W-1:0] wr_cell,
   output logic [NUM_OUT-1:0] q_full,
   input  logic [NUM_OUT-1:0] rd_grant,
   output logic              rd_valid,
   output logic [CELL_W-1:0] rd_cell,
   output logic              rd_err,
   output logic [NUM_OUT-1:0] q_nonempty
);
   generate
      if (NUM_OUT < 2 || NUM_OUT > 32 || (NUM_OUT & (NUM_OUT - 1)) != 0)
         $error("NUM_OUT must be a power of two between 2 and 32");
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
         $error("DEPTH must be a power of two of at least 2");
      if (CELL_W < 1)
         $error("CELL_W must be positive");
   endgenerate

   logic [NUM_OUT-1:0]       push_vec, pop_vec, empty_v, full_v;
   logic [PTR_W-1:0]         wr_ptr_a [NUM_OUT];
   logic [PTR_W-1:0]         rd_ptr_a [NUM_OUT];
   logic [NUM_OUT*CNT_W-1:0] occ_flat;
   logic [PORT_W-1:0]        sel_idx;
   logic                     any_grant;
   logic [CELL_W-1:0]        ram_q;

   // Grant selection: lowest-indexed request wins
   always_comb begin
      any_grant = |rd_grant;
      sel_idx   = PORT_W'(voq_pkg::lowest_set(32'(rd_grant), NUM_OUT));
   end

   for (genvar k = 0; k < NUM_OUT; k++) begin : g_q
      assign push_vec[k] = wr_valid && (wr_port == PORT_W'(k)) && !full_v[k];
      assign pop_vec[k]  = any_grant && (sel_idx == PORT_W'(k)) && !empty_v[k];

      voq_queue_ctrl #(.DEPTH(DEPTH)) u_ctrl (
         .clk    (clk),
         .rst_n  (rst_n),
         .push   (push_vec[k]),
         .pop    (pop_vec[k]),
         .wr_ptr (wr_ptr_a[k]),
         .rd_ptr (rd_ptr_a[k]),
         .occ    (occ_flat[k*CNT_W +: CNT_W]),
         .empty  (empty_v[k]),
         .full   (full_v[k])
      );
   end

   voq_cell_ram #(.WIDTH(CELL_W), .WORDS(WORDS)) u_ram (
      .clk   (clk),
      .we    (|push_vec),
      .waddr ({wr_port, wr_ptr_a[wr_port]}),
      .wdata (wr_cell),
      .raddr ({sel_idx, rd_ptr_a[sel_idx]}),
      .rdata (ram_q)
   );

   assign rd_valid   = |pop_vec;
   assign rd_cell    = rd_valid ? ram_q : '0;
   assign rd_err     = any_grant && empty_v[sel_idx];
   assign q_full     = full_v;
   assign q_nonempty = ~empty_v;
endmodule

// File: rtl/voq_buffer_chk.sv
module voq_buffer_chk #(
   parameter int NUM_OUT = 4,
   parameter int DEPTH   = 8,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_OUT-1:0]       rd_grant,
   input logic                     rd_valid,
   input logic                     rd_err,
   input logic [NUM_OUT-1:0]       q_nonempty,
   input logic [NUM_OUT-1:0]       q_full,
   input logic [NUM_OUT-1:0]       push_vec,
   input logic [NUM_OUT-1:0]       pop_vec,
   input logic [NUM_OUT*CNT_W-1:0] occ_flat
);
   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (q_nonempty == '0 && q_full == '0));

   assert_one_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pop_vec));

   assert_pop_from_filled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_vec != '0) |-> ((pop_vec & q_nonempty) != '0));

   assert_err_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |-> (!rd_valid && rd_grant != '0));

   assert_err_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_err && push_vec == '0) |=> $stable(occ_flat));

   for (genvar k = 0; k < NUM_OUT; k++) begin : g_chk
      assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
         push_vec[k] |-> (occ_flat[k*CNT_W +: CNT_W] < CNT_W'(DEPTH)));

      assert_occ_grow_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (push_vec[k] && !pop_vec[k]) |=>
            (occ_flat[k*CNT_W +: CNT_W] == $past(occ_flat[k*CNT_W +: CNT_W]) + 1'b1));

      assert_same_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (push_vec[k] && pop_vec[k]) |=> $stable(occ_flat[k*CNT_W +: CNT_W]));
   end
endmodule

bind voq_buffer voq_buffer_chk #(.NUM_OUT(NUM_OUT), .DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_grant   (rd_grant),
   .rd_valid   (rd_valid),
   .rd_err     (rd_err),
   .q_nonempty (q_nonempty),
   .q_full     (q_full),
   .push_vec   (push_vec),
   .pop_vec    (pop_vec),
   .occ_flat   (occ_flat)
);

// File: tb/voq_buffer_test.sv
module voq_buffer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [1:0]  wr_port = '0;
   logic [31:0] wr_cell = '0;
   logic [3:0]  rd_grant = '0;
   logic [3:0]  q_full, q_nonempty;
   logic        rd_valid, rd_err;
   logic [31:0] rd_cell;

   int checks = 0;
   int errors = 0;
   logic [31:0] mq [4][$];

   always #4 clk = ~clk;

   voq_buffer uut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_port(wr_port),
      .wr_cell(wr_cell), .q_full(q_full), .rd_grant(rd_grant),
      .rd_valid(rd_valid), .rd_cell(rd_cell), .rd_err(rd_err),
      .q_nonempty(q_nonempty)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // One cycle: called at a falling edge, returns at the next falling edge
   task automatic step(input bit wv, input int wp, input logic [31:0] wd,
                       input logic [3:0] g, input string ctx);
      logic [3:0] ene, efu;
      bit ev, ee;
      logic [31:0] ed;
      int sel;
      bit wr_ok;
      for (int k = 0; k < 4; k++) begin
         ene[k] = mq[k].size() > 0;
         efu[k] = mq[k].size() == 8;
      end
      chk(q_nonempty === ene, {"R2 nonempty ", ctx}, 32'(q_nonempty), 32'(ene));
      chk(q_full === efu, {"R5 full ", ctx}, 32'(q_full), 32'(efu));
      wr_valid = wv; wr_port = 2'(wp); wr_cell = wd; rd_grant = g;
      #1;
      sel = -1;
      for (int k = 3; k >= 0; k--) if (g[k]) sel = k;
      ev = 0; ee = 0; ed = '0;
      if (sel >= 0) begin
         if (mq[sel].size() > 0) begin ev = 1; ed = mq[sel][0]; end
         else ee = 1;
      end
      chk(rd_valid === ev, {"R3 valid ", ctx}, 32'(rd_valid), 32'(ev));
      chk(rd_cell === ed, {"R3 data ", ctx}, rd_cell, ed);
      chk(rd_err === ee, {"R6 err ", ctx}, 32'(rd_err), 32'(ee));
      wr_ok = wv && mq[wp].size() < 8;
      if (ev) void'(mq[sel].pop_front());
      if (wr_ok) mq[wp].push_back(wd);
      @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(q_nonempty === 4'h0, "R1 nonempty in reset", 32'(q_nonempty), 0);
      chk(q_full === 4'h0, "R1 full in reset", 32'(q_full), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(q_nonempty === 4'h0 && q_full === 4'h0, "R1 after reset", 32'({q_full, q_nonempty}), 0);
      chk(rd_valid === 1'b0, "R1 no read", 32'(rd_valid), 0);

      step(1, 1, 32'hA1, 4'b0000, "R2 q1");
      step(1, 1, 32'hA2, 4'b0000, "R2 q1");
      step(1, 2, 32'hB1, 4'b0000, "R2 q2");
      step(1, 1, 32'hA3, 4'b0000, "R2 q1");
      step(1, 2, 32'hB2, 4'b0000, "R2 q2");
      step(0, 0, 32'h0, 4'b0100, "R3 pop q2");
      step(0, 0, 32'h0, 4'b0010, "R3 pop q1");
      for (int i = 0; i < 10; i++) step(1, 0, 32'hC0 + 32'(i), 4'b0000, "R5 fill q0");
      step(1, 0, 32'hDD, 4'b0010, "R4 R5 q0 blocked, q1 served");
      step(1, 3, 32'hE1, 4'b1000, "R6 R7 grant q3 while writing it");
      step(0, 0, 32'h0, 4'b1000, "R3 pop q3");
      step(0, 0, 32'h0, 4'b1000, "R6 grant empty q3");
      step(1, 2, 32'hB3, 4'b0100, "R7 write+read q2");
      step(0, 0, 32'h0, 4'b0000, "R7 occupancy kept");
      step(0, 0, 32'h0, 4'b0110, "R8 multi grant");
      step(0, 0, 32'h0, 4'b1111, "R8 all grant");
      for (int i = 0; i < 10; i++) step(0, 0, 32'h0, 4'b0001, "R5 drain q0");
      step(0, 0, 32'h0, 4'b0100, "R3 drain q2");
      for (int i = 0; i < 3000; i++) begin
         logic [3:0] g;
         g = (($urandom % 3) == 0) ? 4'(1 << ($urandom % 4)) : 4'($urandom % 16);
         if (($urandom % 4) == 0) g = 4'h0;
         step(($urandom % 3) != 0, int'($urandom % 4), $urandom, g, "R4 R7 random");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule